// File: doc/BRIEF.md
# Slave Timing Mismatch Refresh Detector

This block sits inside a column driver running as a slave. The master drives two row level-select bits to every chip, and each slave produces its own copies of the same bits from its local timing chain. Once per half-frame, on the rising edge of the active-low frame marker, the block compares the received pair with the local pair. If either bit differs, the slave pulls a shared open-drain refresh line low for a fixed number of clocks. The line is wired-OR between all chips on the panel.

Whenever the sensed refresh line is low, whichever chip pulled it, the block holds the chip's timing generators in reset and blanks the display. After the line returns high, blanking continues for a set number of frames. The block counts these frames as rising frame-marker edges, two per frame. A chip strapped as master skips the comparison, but it still obeys the shared line. Palette storage is outside this block and a refresh does not touch it. Only the chip reset restores the palette.

Top module: `refresh_detect`

## Requirements
- R1: While `rst_n` is low, `refresh_drive` is 0, `timing_rst` is 0 (with the line high) and `blank` is 1. After release, `blank` stays 1 until the 8th rising edge of `frm_n` has been sampled.
- R2: The comparison is made only in the cycle where `frm_n` is sampled high after being low. A pair mismatch at any other time does not assert `refresh_drive`.
- R3: A difference in either bit (`mst_l1` vs `loc_l1` or `mst_l2` vs `loc_l2`) at a compared edge asserts `refresh_drive` from the next clock. It stays asserted for exactly DRIVE_CLKS (4) clocks and then drops. Matching pairs never assert it.
- R4: While `is_master` is 1, no mismatch asserts `refresh_drive`.
- R5: `timing_rst` is 1 in exactly the cycles in which `refresh_in_n` is low.
- R6: `blank` is 1 while `refresh_in_n` is low. After the line goes high, `blank` stays 1 until 8 rising frame-marker edges (4 frames) have been sampled, and it is 0 from the clock after the 8th.
- R7: A mismatch found while blanking is still counting down restarts the full 8-edge count from the moment the line is released again.
- R8: Rising frame-marker edges that occur while `refresh_in_n` is low are neither compared nor counted toward the blanking period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low chip reset |
| is_master | input | 1 | 1 when this chip is the timing master; disables comparison |
| frm_n | input | 1 | Active-low frame marker, two rising edges per frame |
| mst_l1 | input | 1 | Level-select bit 1 received from the master |
| mst_l2 | input | 1 | Level-select bit 2 received from the master |
| loc_l1 | input | 1 | Locally generated level-select bit 1 |
| loc_l2 | input | 1 | Locally generated level-select bit 2 |
| refresh_in_n | input | 1 | Sensed level of the shared refresh line, low = refresh |
| refresh_drive | output | 1 | 1 enables the open-drain pull-down on the refresh line |
| timing_rst | output | 1 | Internal timing generator reset |
| blank | output | 1 | Display blanking flag |

## Verification
The frame marker's rising edge is seen in the first clock where `frm_n` is high. Both `refresh_drive` and the change in the blanking count land on that same clock edge, so the bench sets `frm_n` high at a falling edge and reads the outputs at the next falling edge. `timing_rst` is combinational from the line, so the bench reads it half a clock after it changes the line. The bench treats the line as the wired-OR of the block's own drive and an external pull. It counts the drive length at successive falling edges. It counts blanking edge by edge and checks that `blank` is still 1 after the 7th edge and 0 after the 8th.

// File: rtl/refresh_detect.sv
module refresh_detect #(
  parameter int DRIVE_CLKS      = 4,
  parameter int BLANK_FRAMES    = 4,
  parameter int EDGES_PER_FRAME = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic is_master,
  input  logic frm_n,
  input  logic mst_l1,
  input  logic mst_l2,
  input  logic loc_l1,
  input  logic loc_l2,
  input  logic refresh_in_n,
  output logic refresh_drive,
  output logic timing_rst,
  output logic blank
);
  localparam int BLANK_EDGES = BLANK_FRAMES * EDGES_PER_FRAME;
  localparam int DW = $clog2(DRIVE_CLKS + 1);
  localparam int CW = $clog2(BLANK_EDGES + 1);

  logic          frm_q;
  logic [DW-1:0] drv_cnt;
  logic [CW-1:0] blk_cnt;

  wire line_low = ~refresh_in_n;
  wire frm_rise = frm_n & ~frm_q;
  wire differ   = (mst_l1 ^ loc_l1) | (mst_l2 ^ loc_l2);
  wire hit      = frm_rise & ~is_master & ~line_low & differ;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) frm_q <= 1'b1;
    else        frm_q <= frm_n;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)             drv_cnt <= '0;
    else if (hit)           drv_cnt <= DW'(DRIVE_CLKS);
    else if (drv_cnt != '0) drv_cnt <= drv_cnt - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                            blk_cnt <= CW'(BLANK_EDGES);
    else if (line_low || hit)              blk_cnt <= CW'(BLANK_EDGES);
    else if (frm_rise && blk_cnt != '0)    blk_cnt <= blk_cnt - 1'b1;

  assign refresh_drive = drv_cnt != '0;
  assign timing_rst    = line_low;
  assign blank         = line_low | (blk_cnt != '0);

  // R3: a new drive only starts after a sampled frame edge
  p_drive_on_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(refresh_drive) |-> $past(frm_n) && !$past(frm_q));

  // R4: a master never starts a drive
  p_master_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(is_master) |-> !$rose(refresh_drive));

  // R6: line low always blanks
  p_blank_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
    line_low |-> blank);

  // R6: blanking ends only on a frame edge
  p_blank_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(blank) |-> $past(frm_n) && !$past(frm_q) && $past(refresh_in_n));

  // R8: a low line keeps blanking into the next cycle
  p_hold_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    line_low |=> blank);
endmodule

// File: tb/refresh_detect_bench.sv
`timescale 1ns/1ps
module refresh_detect_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic is_master = 1'b0;
  logic frm_n = 1'b1;
  logic mst_l1 = 1'b0, mst_l2 = 1'b0, loc_l1 = 1'b0, loc_l2 = 1'b0;
  logic ext_pull = 1'b0;
  logic refresh_drive, timing_rst, blank;
  wire  refresh_in_n = ~(refresh_drive | ext_pull);

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  refresh_detect u_refresh_detect (
    .clk(clk), .rst_n(rst_n), .is_master(is_master), .frm_n(frm_n),
    .mst_l1(mst_l1), .mst_l2(mst_l2), .loc_l1(loc_l1), .loc_l2(loc_l2),
    .refresh_in_n(refresh_in_n), .refresh_drive(refresh_drive),
    .timing_rst(timing_rst), .blank(blank)
  );

  // {is_master, mst_l1, mst_l2, loc_l1, loc_l2, expected drive}
  localparam logic [5:0] VEC [0:7] = '{
    6'b0_10_10_0, 6'b0_01_01_0, 6'b0_10_11_1, 6'b0_00_10_1,
    6'b0_11_00_1, 6'b1_10_01_0, 6'b1_11_11_0, 6'b0_01_00_1
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic frame_edge();
    frm_n = 1'b0;
    tick();
    frm_n = 1'b1;
    tick();
  endtask

  task automatic set_pairs(input logic a, input logic b, input logic c, input logic d);
    mst_l1 = a; mst_l2 = b; loc_l1 = c; loc_l2 = d;
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cnt;
    tick(); tick();
    chk(refresh_drive == 1'b0, "R1 drive in reset", refresh_drive, 0);
    chk(timing_rst == 1'b0, "R1 timing_rst in reset", timing_rst, 0);
    chk(blank == 1'b1, "R1 blank in reset", blank, 1);
    rst_n = 1'b1;
    tick();
    for (int k = 0; k < 7; k++) frame_edge();
    chk(blank == 1'b1, "R1 blank after 7 edges", blank, 1);
    frame_edge();
    chk(blank == 1'b0, "R1 blank after 8 edges", blank, 0);

    // R2 R3 R4 vector walk
    for (int i = 0; i < 8; i++) begin
      is_master = VEC[i][5];
      set_pairs(VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1]);
      frame_edge();
      chk(refresh_drive == VEC[i][0], VEC[i][5] ? "R4 master vector" : "R3 compare vector",
          refresh_drive, VEC[i][0]);
      repeat (8) tick();
    end
    is_master = 1'b0;

    // R2: mismatch without an edge
    set_pairs(1, 0, 0, 1);
    repeat (6) tick();
    chk(refresh_drive == 1'b0, "R2 no edge no drive", refresh_drive, 0);

    // R3 drive length
    frame_edge();
    cnt = 0;
    while (refresh_drive && cnt < 20) begin cnt++; tick(); end
    chk(cnt == 4, "R3 drive length", cnt, 4);
    set_pairs(0, 0, 0, 0);
    for (int k = 0; k < 8; k++) frame_edge();
    chk(blank == 1'b0, "R6 blank cleared", blank, 0);

    // R5 R8 external pull
    ext_pull = 1'b1;
    #1;
    chk(timing_rst == 1'b1, "R5 timing_rst follows low line", timing_rst, 1);
    tick();
    chk(blank == 1'b1, "R6 blank while line low", blank, 1);
    set_pairs(1, 1, 0, 0);
    frame_edge();
    chk(refresh_drive == 1'b0, "R8 no compare while low", refresh_drive, 0);
    frame_edge(); frame_edge();
    set_pairs(0, 0, 0, 0);
    ext_pull = 1'b0;
    #1;
    chk(timing_rst == 1'b0, "R5 timing_rst released", timing_rst, 0);
    tick();
    for (int k = 0; k < 7; k++) frame_edge();
    chk(blank == 1'b1, "R8 low edges not counted", blank, 1);
    frame_edge();
    chk(blank == 1'b0, "R6 blank ends at 8th edge", blank, 0);

    // R7 restart during blanking
    ext_pull = 1'b1; tick(); ext_pull = 1'b0; tick();
    for (int k = 0; k < 3; k++) frame_edge();
    set_pairs(0, 1, 0, 0);
    frame_edge();
    chk(refresh_drive == 1'b1, "R7 mismatch while blanking", refresh_drive, 1);
    set_pairs(0, 0, 0, 0);
    repeat (6) tick();
    for (int k = 0; k < 7; k++) frame_edge();
    chk(blank == 1'b1, "R7 count restarted", blank, 1);
    frame_edge();
    chk(blank == 1'b0, "R7 blank ends after full count", blank, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule